// File: doc/BRIEF.md
# Video Memory Access Adapter

This block is a bus slave that sits between a 32-bit processor bus and three small on-chip video memories: a colour palette store, a pixel/tile store and a sprite attribute store. The processor issues byte, halfword or word reads and writes. The adapter decodes which store is addressed, works out the halfword lanes to update, and applies the write-width rules of each store. In the palette store and the lower part of the pixel store, a single byte is spread across a whole halfword. Elsewhere a lone byte is thrown away.

The pixel store window is larger than the storage behind it. The top quarter of the window folds back onto the quarter below it. When a bitmap display mode is selected, the lower half of that top quarter is dead space: reads of it see the bus's floating value and writes to it vanish. While the display is scanning its visible area, every access to any of the three stores costs one extra cycle, signalled by holding ready low for a cycle. The stores are plain arrays inside the block, written at a clock edge and read combinationally.

Top module: `vid_mem_adapter`

## Requirements
- R1: Address bits [27:24] pick the target: 5 is the palette store, 6 the pixel store, 7 the sprite store. A request with any other code completes with ready in its first cycle, returns rdata 0 and writes nothing.
- R2: size 0 is a byte, size 1 a halfword, size 2 a word. A halfword access clears address bit 0 and a word access clears bits [1:0]. Write values come from the low bits of wdata. A word is stored little-endian. Byte and halfword reads return the addressed lane zero-extended in rdata.
- R3: A palette byte write whose offset addr[23:0] is at most PRAM_BYTES-1 (0x3FF by default) writes the byte to both halves of the aligned halfword. A palette byte write at a larger offset is dropped. Palette halfword and word accesses, and all palette reads, wrap modulo PRAM_BYTES.
- R4: A pixel-store byte write is copied into both halves of the aligned halfword only if its offset, after the fold of R6, is at most the limit. The limit is WIN/2-1 (0x7FF by default) outside bitmap mode and 5*WIN/8-1 (0x9FF by default) in bitmap mode. Byte writes above the limit are dropped.
- R5: Byte writes to the sprite store change nothing. Halfword and word writes to it, and all reads from it, work normally and wrap modulo OAM_BYTES.
- R6: The pixel-store offset is addr[WIN_AW-1:0], with window size WIN = 2^WIN_AW. An offset at or above 3*WIN/4 (0xC00 by default) is reduced by WIN/4 (0x400) before the access.
- R7: In bitmap mode, a pixel-store offset in [3*WIN/4, 7*WIN/8) (0xC00 to 0xDFF by default) is invalid. A read of it returns openbus_data unchanged and a write to it is dropped. Outside bitmap mode the same offsets fold as in R6.
- R8: While disp_visible is high, an access to any of the three stores sees ready low in its first cycle and high in its second, so it takes exactly one wait cycle.
- R9: While disp_visible is low, an access to a store sees ready high in its first cycle.
- R10: A write takes effect at the rising edge where req and ready are both high. Read data is valid whenever ready is high, and a later read returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until ready |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 0 byte, 1 halfword, 2 word |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write value, low-aligned |
| bitmap_mode | input | 1 | Display is in a bitmap mode |
| disp_visible | input | 1 | Display is in its visible period |
| openbus_data | input | 32 | Value returned for invalid pixel-store reads |
| ready | output | 1 | Access completes this cycle |
| rdata | output | 32 | Read data, valid with ready |

## Verification
The bench pushes byte writes to both sides of each replication limit, in both display modes. A design with the wrong limit would corrupt a halfword that should stay intact, or leave one unwritten. It reads the folded top quarter of the pixel store against its alias below. A missing or misplaced fold would return the wrong word or fail to write through the alias. It writes to the invalid bitmap window and then reads the alias in tile mode to prove nothing landed there. It also counts wait cycles per access, so a design that stalls twice, never stalls, or stalls outside the three stores is caught. Random mixed traffic is compared with a byte-level model of all three stores.

// File: rtl/vma_pkg.sv
package vma_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  localparam logic [3:0] RGN_PAL  = 4'd5;
  localparam logic [3:0] RGN_VRAM = 4'd6;
  localparam logic [3:0] RGN_OAM  = 4'd7;
endpackage

// File: rtl/vma_decode.sv
module vma_decode
  import vma_pkg::*;
#(
  parameter int PRAM_AW = 10,
  parameter int WIN_AW  = 12,
  parameter int OAM_AW  = 10,
  parameter int IDX_W   = 10
) (
  input  logic [31:0]      addr,
  input  logic [1:0]       size,
  input  logic             bitmap_mode,
  output logic             sel_pal,
  output logic             sel_vram,
  output logic             sel_oam,
  output logic             invalid,
  output logic             wr_ok,
  output logic [1:0]       lane_en,
  output logic [IDX_W-1:0] idx
);
  localparam int WIN_BYTES = 1 << WIN_AW;
  localparam logic [WIN_AW-1:0] V_MIR     = WIN_AW'(WIN_BYTES * 3 / 4);
  localparam logic [WIN_AW-1:0] V_SHIFT   = WIN_AW'(WIN_BYTES / 4);
  localparam logic [WIN_AW-1:0] V_INV_END = WIN_AW'(WIN_BYTES * 7 / 8);
  localparam logic [WIN_AW-1:0] LIM_TILE  = WIN_AW'(WIN_BYTES / 2 - 1);
  localparam logic [WIN_AW-1:0] LIM_BMP   = WIN_AW'(WIN_BYTES * 5 / 8 - 1);

  logic [3:0]        rgn;
  logic [WIN_AW-1:0] voff;
  logic [WIN_AW-1:0] vrem;
  logic              v_hi;
  logic              is_byte;
  logic              p_byte_ok;
  logic              v_byte_ok;

  always_comb begin
    rgn       = addr[27:24];
    sel_pal   = (rgn == RGN_PAL);
    sel_vram  = (rgn == RGN_VRAM);
    sel_oam   = (rgn == RGN_OAM);
    is_byte   = (acc_size_e'(size) == SZ_BYTE);

    voff      = addr[WIN_AW-1:0];
    v_hi      = (voff >= V_MIR);
    vrem      = v_hi ? (voff - V_SHIFT) : voff;
    invalid   = sel_vram && bitmap_mode && v_hi && (voff < V_INV_END);

    p_byte_ok = (addr[23:PRAM_AW] == '0);
    v_byte_ok = (vrem <= (bitmap_mode ? LIM_BMP : LIM_TILE));

    if (sel_pal)       wr_ok = !is_byte || p_byte_ok;
    else if (sel_vram) wr_ok = !invalid && (!is_byte || v_byte_ok);
    else if (sel_oam)  wr_ok = !is_byte;
    else               wr_ok = 1'b0;

    if (acc_size_e'(size) == SZ_WORD) lane_en = 2'b11;
    else                              lane_en = addr[1] ? 2'b10 : 2'b01;

    if (sel_vram)     idx = IDX_W'(vrem[WIN_AW-1:2]);
    else if (sel_oam) idx = IDX_W'(addr[OAM_AW-1:2]);
    else              idx = IDX_W'(addr[PRAM_AW-1:2]);
  end
endmodule

// File: rtl/vma_wordram.sv
module vma_wordram #(
  parameter int WORDS = 256,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [1:0]    lane_en,
  input  logic [AW-1:0] idx,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [15:0] mem [WORDS];
    always_ff @(posedge clk) begin
      if (wr_en && lane_en[g]) mem[idx] <= wdata[16*g +: 16];
    end
    assign rdata[16*g +: 16] = mem[idx];
  end
endmodule

// File: rtl/vid_mem_adapter.sv
module vid_mem_adapter
  import vma_pkg::*;
#(
  parameter int PRAM_AW = 10,
  parameter int WIN_AW  = 12,
  parameter int OAM_AW  = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [1:0]  size,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  input  logic        bitmap_mode,
  input  logic        disp_visible,
  input  logic [31:0] openbus_data,
  output logic        ready,
  output logic [31:0] rdata
);
  localparam int PRAM_WORDS = 1 << (PRAM_AW - 2);
  localparam int VRAM_WORDS = 3 << (WIN_AW - 4);
  localparam int OAM_WORDS  = 1 << (OAM_AW - 2);
  localparam int MAX_AW     = (WIN_AW > PRAM_AW) ? ((WIN_AW > OAM_AW) ? WIN_AW : OAM_AW)
                                                 : ((PRAM_AW > OAM_AW) ? PRAM_AW : OAM_AW);
  localparam int IDX_W      = MAX_AW - 2;
  localparam int PIW        = $clog2(PRAM_WORDS);
  localparam int VIW        = $clog2(VRAM_WORDS);
  localparam int OIW        = $clog2(OAM_WORDS);

  logic             sel_pal, sel_vram, sel_oam, is_vid;
  logic             invalid, wr_ok;
  logic [1:0]       lane_en;
  logic [IDX_W-1:0] idx;
  logic [31:0]      wr_word, pal_rd, vram_rd, oam_rd, rd_word;
  logic             commit_wr, pal_we, vram_we, oam_we;
  logic             wait_q, wait_d, wait_en;

  vma_decode #(
    .PRAM_AW(PRAM_AW), .WIN_AW(WIN_AW), .OAM_AW(OAM_AW), .IDX_W(IDX_W)
  ) u_dec (
    .addr(addr), .size(size), .bitmap_mode(bitmap_mode),
    .sel_pal(sel_pal), .sel_vram(sel_vram), .sel_oam(sel_oam),
    .invalid(invalid), .wr_ok(wr_ok), .lane_en(lane_en), .idx(idx)
  );

  // Wait-state control: next-state logic and register kept apart.
  always_comb begin
    is_vid  = sel_pal || sel_vram || sel_oam;
    ready   = req && (!is_vid || !disp_visible || wait_q);
    wait_en = 1'b1;
    wait_d  = req && !ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wait_q <= 1'b0;
    else if (wait_en) wait_q <= wait_d;
  end

  // Write data lane formatting.
  always_comb begin
    case (acc_size_e'(size))
      SZ_BYTE: wr_word = {4{wdata[7:0]}};
      SZ_HALF: wr_word = {2{wdata[15:0]}};
      default: wr_word = wdata;
    endcase
    commit_wr = req && ready && we && wr_ok;
    pal_we    = commit_wr && sel_pal;
    vram_we   = commit_wr && sel_vram;
    oam_we    = commit_wr && sel_oam;
  end

  vma_wordram #(.WORDS(PRAM_WORDS)) u_pal (
    .clk(clk), .wr_en(pal_we), .lane_en(lane_en), .idx(idx[PIW-1:0]),
    .wdata(wr_word), .rdata(pal_rd)
  );

  vma_wordram #(.WORDS(VRAM_WORDS)) u_vram (
    .clk(clk), .wr_en(vram_we), .lane_en(lane_en), .idx(idx[VIW-1:0]),
    .wdata(wr_word), .rdata(vram_rd)
  );

  vma_wordram #(.WORDS(OAM_WORDS)) u_oam (
    .clk(clk), .wr_en(oam_we), .lane_en(lane_en), .idx(idx[OIW-1:0]),
    .wdata(wr_word), .rdata(oam_rd)
  );

  // Read data selection and lane extraction.
  always_comb begin
    if (sel_vram)     rd_word = vram_rd;
    else if (sel_oam) rd_word = oam_rd;
    else              rd_word = pal_rd;

    if (!is_vid)      rdata = 32'h0;
    else if (invalid) rdata = openbus_data;
    else begin
      case (acc_size_e'(size))
        SZ_BYTE: rdata = {24'h0, rd_word[{addr[1:0], 3'b000} +: 8]};
        SZ_HALF: rdata = {16'h0, addr[1] ? rd_word[31:16] : rd_word[15:0]};
        default: rdata = rd_word;
      endcase
    end
  end

  // R8: a stalled request completes in the next cycle.
  a_r8_single_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ready) |=> (ready || !req));

  // R1: requests outside the three stores never stall.
  a_r1_other_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !is_vid) |-> ready);

  // R9: no stall outside the visible period.
  a_r9_blank_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !disp_visible) |-> ready);

  // R5: a byte write to the sprite store never reaches its array.
  a_r5_oam_byte_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && sel_oam && (acc_size_e'(size) == SZ_BYTE)) |-> !oam_we);

  // R7: the invalid bitmap window never reaches the pixel array.
  a_r7_invalid_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req && invalid) |-> !vram_we);

  // R6: the folded pixel index always lies inside the array.
  a_r6_fold_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (req && sel_vram) |-> (int'(idx) < VRAM_WORDS));

  // R1: at most one store selected.
  a_r1_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pal_we, vram_we, oam_we}));
endmodule

// File: tb/test_vid_mem_adapter.sv
module test_vid_mem_adapter;
  localparam int MB_PAL  = 0;
  localparam int MB_VRAM = 1024;
  localparam int MB_OAM  = 4096;

  logic        clk, rst_n, req, we, bitmap_mode, disp_visible, ready;
  logic [1:0]  size;
  logic [31:0] addr, wdata, openbus_data, rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [7:0] mdl [5120];

  vid_mem_adapter i_vid_mem_adapter (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .size(size), .addr(addr),
    .wdata(wdata), .bitmap_mode(bitmap_mode), .disp_visible(disp_visible),
    .openbus_data(openbus_data), .ready(ready), .rdata(rdata)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Model byte location for a read/write (lo = local byte offset); returns -1 when invalid.
  function automatic int mloc(input logic [31:0] a, input bit bm);
    int off;
    case (a[27:24])
      4'd5: return MB_PAL + int'(a[9:0]);
      4'd6: begin
        off = int'(a[11:0]);
        if (off >= 3072) begin
          if (bm && off < 3584) return -1;
          off -= 1024;
        end
        return MB_VRAM + off;
      end
      4'd7: return MB_OAM + int'(a[9:0]);
      default: return -2;
    endcase
  endfunction

  task automatic model_write(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d, input bit bm);
    int loc, lim;
    loc = mloc(a, bm);
    if (loc < 0) return;
    if (sz == 2'd0) begin
      if (a[27:24] == 4'd7) return;
      if (a[27:24] == 4'd5 && a[23:0] > 24'h3FF) return;
      if (a[27:24] == 4'd6) begin
        lim = bm ? 2559 : 2047;
        if (loc - MB_VRAM > lim) return;
      end
      loc = loc & ~1;
      mdl[loc] = d[7:0]; mdl[loc+1] = d[7:0];
    end else if (sz == 2'd1) begin
      loc = loc & ~1;
      mdl[loc] = d[7:0]; mdl[loc+1] = d[15:8];
    end else begin
      loc = loc & ~3;
      for (int k = 0; k < 4; k++) mdl[loc+k] = d[8*k +: 8];
    end
  endtask

  function automatic logic [31:0] model_read(input logic [31:0] a, input logic [1:0] sz, input bit bm, input logic [31:0] ob);
    int loc;
    loc = mloc(a, bm);
    if (loc == -2) return 32'h0;
    if (loc == -1) return ob;
    if (sz == 2'd0) return {24'h0, mdl[loc]};
    if (sz == 2'd1) begin
      loc = loc & ~1;
      return {16'h0, mdl[loc+1], mdl[loc]};
    end
    loc = loc & ~3;
    return {mdl[loc+3], mdl[loc+2], mdl[loc+1], mdl[loc]};
  endfunction

  task automatic access(input logic w, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d,
                        input logic bm, input logic vis, input logic [31:0] ob,
                        output logic [31:0] rd, output int waits);
    @(negedge clk);
    req = 1; we = w; size = sz; addr = a; wdata = d;
    bitmap_mode = bm; disp_visible = vis; openbus_data = ob;
    waits = 0;
    #1;
    while (!ready && waits < 4) begin
      @(posedge clk); #1;
      waits++;
    end
    rd = rdata;
    @(posedge clk); #1;
    req = 0; we = 0;
  endtask

  // One checked operation: wait count always, read data on reads.
  task automatic op(input logic w, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d,
                    input logic bm, input logic vis, input string tag);
    logic [31:0] rd, ob, exp;
    int waits, expw;
    ob = $urandom;
    expw = (vis && a[27:24] >= 4'd5 && a[27:24] <= 4'd7) ? 1 : 0;
    access(w, sz, a, d, bm, vis, ob, rd, waits);
    chk(waits == expw, {tag, " R8/R9 wait count"}, 32'(waits), 32'(expw));
    if (w) model_write(a, sz, d, bm);
    else begin
      exp = model_read(a, sz, bm, ob);
      chk(rd === exp, {tag, " R10 read data"}, rd, exp);
    end
  endtask

  function automatic logic [31:0] rnd_addr();
    int r;
    r = $urandom % 20;
    if (r == 0) return {4'h0, 4'd3, 24'($urandom % 4096)};
    if (r < 7)  return {4'h0, 4'd5, 24'($urandom % 2048)};
    if (r < 15) return {4'h0, 4'd6, 24'($urandom % 4096)};
    return {4'h0, 4'd7, 24'($urandom % 2048)};
  endfunction

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int w;
    void'($urandom(32'h5EED1234));
    rst_n = 0; req = 0; we = 0; size = 0; addr = 0; wdata = 0;
    bitmap_mode = 0; disp_visible = 0; openbus_data = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(ready == 1'b0, "R8 reset: ready low without request", 32'(ready), 32'h0);
    @(negedge clk); rst_n = 1;

    // Fill every store word with known data (tile mode, blank period).
    for (int i = 0; i < 256; i++) begin
      access(1, 2'd2, {8'h05, 24'(4*i)}, $urandom, 0, 0, 0, rd, w);
      model_write({8'h05, 24'(4*i)}, 2'd2, wdata, 0);
    end
    for (int i = 0; i < 768; i++) begin
      access(1, 2'd2, {8'h06, 24'(4*i)}, $urandom, 0, 0, 0, rd, w);
      model_write({8'h06, 24'(4*i)}, 2'd2, wdata, 0);
    end
    for (int i = 0; i < 256; i++) begin
      access(1, 2'd2, {8'h07, 24'(4*i)}, $urandom, 0, 0, 0, rd, w);
      model_write({8'h07, 24'(4*i)}, 2'd2, wdata, 0);
    end

    // R3: palette byte replication at the top offset and drop past it.
    op(1, 2'd0, 32'h050003FF, 32'h000000A5, 0, 0, "R3 pal byte at 0x3FF");
    op(0, 2'd1, 32'h050003FE, 0, 0, 0, "R3 pal halfword after byte");
    op(1, 2'd0, 32'h05000410, 32'h0000005A, 0, 1, "R3 pal byte past limit");
    op(0, 2'd2, 32'h05000010, 0, 0, 0, "R3 pal mirror untouched");
    // R4: pixel byte limits in both modes.
    op(1, 2'd0, 32'h060007FF, 32'h00000011, 0, 0, "R4 tile byte at limit");
    op(1, 2'd0, 32'h06000800, 32'h00000022, 0, 0, "R4 tile byte past limit");
    op(0, 2'd2, 32'h060007FC, 0, 0, 0, "R4 tile limit word");
    op(0, 2'd2, 32'h06000800, 0, 0, 0, "R4 tile dropped word");
    op(1, 2'd0, 32'h060009FF, 32'h00000033, 1, 0, "R4 bitmap byte at limit");
    op(1, 2'd0, 32'h06000A00, 32'h00000044, 1, 1, "R4 bitmap byte past limit");
    op(0, 2'd2, 32'h060009FC, 0, 1, 0, "R4 bitmap limit word");
    op(0, 2'd2, 32'h06000A00, 0, 1, 0, "R4 bitmap dropped word");
    // R5: sprite byte writes ignored, halfword works.
    op(1, 2'd0, 32'h07000021, 32'h000000FF, 0, 1, "R5 oam byte");
    op(0, 2'd2, 32'h07000020, 0, 0, 0, "R5 oam after byte");
    op(1, 2'd1, 32'h07000023, 32'h0000BEEF, 0, 0, "R5 oam halfword");
    op(0, 2'd2, 32'h07000020, 0, 0, 0, "R5 oam after halfword");
    // R6: fold of the top quarter onto the quarter below.
    op(1, 2'd2, 32'h06000F04, 32'hCAFEF00D, 1, 0, "R6 write via fold");
    op(0, 2'd2, 32'h06000B04, 0, 0, 0, "R6 read alias below");
    op(1, 2'd2, 32'h06000C08, 32'h12345678, 0, 0, "R6 tile write fold low");
    op(0, 2'd2, 32'h06000808, 0, 0, 1, "R6 alias of tile fold");
    // R7: invalid bitmap window.
    op(0, 2'd2, 32'h06000C10, 0, 1, 0, "R7 invalid read openbus");
    op(0, 2'd0, 32'h06000DFF, 0, 1, 1, "R7 invalid byte read openbus");
    op(1, 2'd2, 32'h06000C10, 32'hDEADBEEF, 1, 0, "R7 invalid write");
    op(0, 2'd2, 32'h06000810, 0, 0, 0, "R7 alias unchanged");
    op(0, 2'd2, 32'h06000E00, 0, 1, 0, "R7 just past invalid window");
    // R1: other region.
    op(1, 2'd2, 32'h03000010, 32'hFFFFFFFF, 0, 1, "R1 other region write");
    op(0, 2'd2, 32'h03000010, 0, 0, 1, "R1 other region read");
    // R2: lanes and alignment.
    op(1, 2'd1, 32'h05000043, 32'hFFFF1357, 0, 0, "R2 half write forced align");
    op(0, 2'd0, 32'h05000043, 0, 0, 0, "R2 byte lane 3");
    op(0, 2'd1, 32'h05000041, 0, 0, 0, "R2 half lane 0");
    op(0, 2'd2, 32'h05000043, 0, 0, 0, "R2 word forced align");

    // Random mixed traffic.
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] sz;
      sz = 2'($urandom % 3);
      op(1'($urandom % 2), sz, rnd_addr(), $urandom, 1'($urandom % 2), 1'($urandom % 2), "R10 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule